// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose writer and reader run on separate, unrelated clocks. It stores up to 1024 words of 18 bits (both sizes are parameters) and reports its state through five active-low flags. Full is driven in the write clock domain. Empty, almost-empty and half-full are driven in the read clock domain. Almost-full is driven in the write domain. Pointers move between the domains as Gray codes through two-stage synchronizers. Each flag therefore settles a few cycles after the far side moves, and it errs on the safe side while it settles.

The two thresholds sit in two 12-bit offset registers. A shared active-low load strobe turns the ports into a configuration path. A write with load low stores the low 12 data bits into an offset register. A read with load low puts an offset register on the low 12 output bits. Each port keeps its own one-bit pointer that alternates between the almost-empty and almost-full registers on every such access. An output-enable input gates the output bus to zero and clears the valid indication. A single active-low reset, sampled on each clock, restores everything.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: While rst_n is low across edges of both clocks, both pointers return to zero, full_n and almost_full_n go high, empty_n and almost_empty_n go low, half_n goes high, and the output register clears to zero.
- R2: On a wr_clk edge with wr_en_n low and load_n high, din is stored only if full_n is high. A write attempted while full_n is low is dropped and leaves stored data and count unchanged.
- R3: On an rd_clk edge with rd_en_n low and load_n high, the oldest word is moved into the output register only if empty_n is high. Otherwise, including whenever rd_en_n is high, the output register keeps its value.
- R4: With load_n low, a write stores din[11:0] into the selected offset register and does not touch the FIFO contents. A read puts the selected offset on dout[11:0], drives dout[17:12] to zero, and removes no word.
- R5: almost_empty_n is low exactly when the stored word count is less than or equal to the almost-empty offset.
- R6: almost_full_n is low exactly when the free space (1024 minus count) is less than or equal to the almost-full offset.
- R7: half_n is low exactly when the count exceeds 512.
- R8: full_n is low exactly when 1024 words are held. empty_n is low exactly when none are held.
- R9: While oe_n is high, dout is zero and dout_valid is low. While oe_n is low, dout shows the output register, and dout_valid is high once that register has been loaded by any read since reset.
- R10: Both offsets reset to 127. The per-port selector starts at the almost-empty register (selector value 0) after reset and flips to the other register after each load access on that port.
- R11: Pointers cross clock domains as Gray codes that change by at most one bit per edge. Once both ports have been idle for a few cycles of the slower clock, every flag matches the true count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled on both clocks |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| load_n | input | 1 | Active-low select of offset registers instead of the FIFO |
| oe_n | input | 1 | Active-low output enable |
| din | input | 18 | Write data; bits 11:0 feed the offset registers |
| dout | output | 18 | Output register, zero while disabled |
| dout_valid | output | 1 | Output enabled and output register loaded |
| full_n | output | 1 | Low when full (write domain) |
| empty_n | output | 1 | Low when empty (read domain) |
| half_n | output | 1 | Low when more than half full (read domain) |
| almost_full_n | output | 1 | Low at or within the full offset (write domain) |
| almost_empty_n | output | 1 | Low at or within the empty offset (read domain) |

## Verification
The assertions assume that load_n is changed only while both enables are high. They also assume that the offset registers are quasi-static when seen from the read domain, and that rst_n is held low across several edges of both clocks. The bench therefore changes load_n and the offsets only with both ports idle. Every burst is either all writes or all reads, so the flag that blocks the active port is never stale. Flags are compared with the queue model only after both sides have been idle long enough for the synchronizers to settle.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
// Shared types for the dual-clock FIFO.
// Assumes nothing beyond the IEEE 1800-2017 language.
package fifo_pkg;
    // Which threshold register a load access on a port reaches next.
    typedef enum logic {
        SEL_EMPTY_OFS = 1'b0,
        SEL_FULL_OFS  = 1'b1
    } ofs_sel_e;
endpackage

// File: rtl/fifo_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer for a Gray-coded pointer.
// Assumes the input changes by at most one bit per source-clock edge.
module fifo_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two flops in series into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fifo_mem.sv
`timescale 1ns/1ps
// Storage array: written on the write clock, read asynchronously by address.
// Assumes the read side registers the read data itself.
module fifo_mem #(
    parameter int DW    = 18,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    // Capture one word per accepted write.
    always_ff @(posedge wr_clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
`timescale 1ns/1ps
// Write-domain control: write pointer, offset registers, full and almost-full.
// Assumes DEPTH is a power of two, PW = log2(DEPTH)+1, and that load_n
// changes only while wr_en_n is high.
module fifo_wr_side
    import fifo_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int DW     = 18,
    parameter int OW     = 12,
    parameter int OFS_RST = 127,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1,
    localparam int CW    = (OW > PW) ? OW : PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          load_n,
    input  logic [DW-1:0] din,
    input  logic [PW-1:0] rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [OW-1:0] ae_ofs,
    output logic [OW-1:0] af_ofs,
    output logic          full_n,
    output logic          almost_full_n
);
    function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
        return b;
    endfunction

    logic [PW-1:0] wbin, wbin_nx, rbin_s, used, free_sp;
    logic          wr_go, wr_cfg;
    ofs_sel_e      wsel;

    assign wr_go   = !wr_en_n && load_n && full_n;
    assign wr_cfg  = !wr_en_n && !load_n;
    assign wbin_nx = wbin + PW'(1);
    assign rbin_s  = to_bin(rgray_s);
    assign used    = wbin - rbin_s;
    assign free_sp = PW'(DEPTH) - used;

    assign full_n        = !(wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    assign almost_full_n = !(CW'(free_sp) <= CW'(af_ofs));
    assign we            = wr_go;
    assign waddr         = wbin[AW-1:0];

    // Advance the binary and Gray write pointers on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_go) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Load the selected offset register and flip the selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_ofs <= OW'(OFS_RST);
            af_ofs <= OW'(OFS_RST);
            wsel   <= SEL_EMPTY_OFS;
        end else if (wr_cfg) begin
            if (wsel == SEL_EMPTY_OFS) ae_ofs <= din[OW-1:0];
            else                       af_ofs <= din[OW-1:0];
            wsel <= (wsel == SEL_EMPTY_OFS) ? SEL_FULL_OFS : SEL_EMPTY_OFS;
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !wr_en_n && load_n) |=> $stable(wbin));
    assert_cfg_keeps_wptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_n && !load_n) |=> $stable(wbin));
    assert_full_is_almost_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !almost_full_n);
    assert_wgray_one_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/fifo_rd_side.sv
`timescale 1ns/1ps
// Read-domain control: read pointer, output register, empty, almost-empty
// and half-full. Assumes the offsets are quasi-static when sampled here and
// that load_n changes only while rd_en_n is high.
module fifo_rd_side
    import fifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 18,
    parameter int OW    = 12,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1,
    localparam int CW   = (OW > PW) ? OW : PW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_n,
    input  logic          load_n,
    input  logic [PW-1:0] wgray_s,
    input  logic [OW-1:0] ae_ofs,
    input  logic [OW-1:0] af_ofs,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [DW-1:0] q,
    output logic          q_loaded,
    output logic          empty_n,
    output logic          almost_empty_n,
    output logic          half_n
);
    function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
        return b;
    endfunction

    logic [PW-1:0] rbin, rbin_nx, wbin_s, held;
    logic [OW-1:0] ofs_pick;
    logic          rd_go, rd_cfg;
    ofs_sel_e      rsel;

    assign rd_go    = !rd_en_n && load_n && empty_n;
    assign rd_cfg   = !rd_en_n && !load_n;
    assign rbin_nx  = rbin + PW'(1);
    assign wbin_s   = to_bin(wgray_s);
    assign held     = wbin_s - rbin;
    assign ofs_pick = (rsel == SEL_EMPTY_OFS) ? ae_ofs : af_ofs;

    assign empty_n        = !(rgray == wgray_s);
    assign almost_empty_n = !(CW'(held) <= CW'(ae_ofs));
    assign half_n         = !(held > PW'(DEPTH / 2));
    assign raddr          = rbin[AW-1:0];

    // Advance the read pointer on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_go) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    // Load the output register from storage or from an offset register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q_loaded <= 1'b0;
            rsel     <= SEL_EMPTY_OFS;
        end else if (rd_go) begin
            q        <= mem_rdata;
            q_loaded <= 1'b1;
        end else if (rd_cfg) begin
            q        <= DW'(ofs_pick);
            q_loaded <= 1'b1;
            rsel     <= (rsel == SEL_EMPTY_OFS) ? SEL_FULL_OFS : SEL_EMPTY_OFS;
        end
    end

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !rd_en_n && load_n) |=> $stable(rbin));
    assert_idle_holds_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_n |=> $stable(q));
    assert_count_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        held <= PW'(DEPTH));
    assert_empty_is_almost_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);
    assert_rgray_one_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dual_clock_flag_fifo.sv
`timescale 1ns/1ps
// Top of the dual-clock FIFO with active-low programmable flags.
// Assumes DEPTH is a power of two, OW <= DW, and rst_n is held low across
// several edges of both clocks.
module dual_clock_flag_fifo #(
    parameter int DEPTH   = 1024,
    parameter int DW      = 18,
    parameter int OW      = 12,
    parameter int OFS_RST = 127,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en_n,
    input  logic          rd_en_n,
    input  logic          load_n,
    input  logic          oe_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_valid,
    output logic          full_n,
    output logic          empty_n,
    output logic          half_n,
    output logic          almost_full_n,
    output logic          almost_empty_n
);
    logic          we, q_loaded;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [OW-1:0] ae_ofs, af_ofs;
    logic [DW-1:0] mem_rdata, q;

    fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(mem_rdata));

    fifo_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    fifo_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    fifo_wr_side #(.DEPTH(DEPTH), .DW(DW), .OW(OW), .OFS_RST(OFS_RST)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .load_n(load_n),
        .din(din), .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .full_n(full_n),
        .almost_full_n(almost_full_n));

    fifo_rd_side #(.DEPTH(DEPTH), .DW(DW), .OW(OW)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .load_n(load_n),
        .wgray_s(wgray_s), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray), .q(q),
        .q_loaded(q_loaded), .empty_n(empty_n),
        .almost_empty_n(almost_empty_n), .half_n(half_n));

    // Output enable gates the bus to zero and drops the valid indication.
    assign dout       = oe_n ? '0 : q;
    assign dout_valid = !oe_n && q_loaded;

    assert_oe_blocks_valid_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        oe_n |-> (!dout_valid && dout == '0));
endmodule

// File: tb/tb_dual_clock_flag_fifo.sv
`timescale 1ns/1ps
// Self-checking bench: directed boundary cases plus seeded random bursts,
// compared with a queue model.
module tb_dual_clock_flag_fifo;
    localparam int DW = 18;
    localparam int DEPTH = 1024;

    logic wr_clk = 0, rd_clk = 0, rst_n = 0;
    logic wr_en_n = 1, rd_en_n = 1, load_n = 1, oe_n = 0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_valid, full_n, empty_n, half_n, almost_full_n, almost_empty_n;

    dual_clock_flag_fifo dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
        .rd_en_n(rd_en_n), .load_n(load_n), .oe_n(oe_n), .din(din),
        .dout(dout), .dout_valid(dout_valid), .full_n(full_n),
        .empty_n(empty_n), .half_n(half_n), .almost_full_n(almost_full_n),
        .almost_empty_n(almost_empty_n));

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz write clock
    always #3.6 rd_clk = ~rd_clk;   // unrelated read clock

    int checks = 0, failures = 0;
    bit done = 0;
    logic [DW-1:0] model[$];
    int ae_m = 127, af_m = 127;
    bit wsel_m = 0, rsel_m = 0, loaded_m = 0;
    logic [DW-1:0] last_q = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk); din = d; wr_en_n = 0;
        @(negedge wr_clk); wr_en_n = 1;
        if (model.size() < DEPTH) model.push_back(d);
    endtask

    task automatic pop(input string tag);
        @(negedge rd_clk); rd_en_n = 0;
        @(negedge rd_clk); rd_en_n = 1;
        if (model.size() > 0) begin last_q = model.pop_front(); loaded_m = 1; end
        chk(dout === last_q, tag, dout, last_q);
    endtask

    task automatic cfg_write(input int v);
        @(negedge wr_clk); load_n = 0; din = DW'(v); wr_en_n = 0;
        @(negedge wr_clk); wr_en_n = 1; load_n = 1;
        if (!wsel_m) ae_m = v & 12'hFFF; else af_m = v & 12'hFFF;
        wsel_m = !wsel_m;
    endtask

    task automatic cfg_read(input string tag);
        int exp;
        exp = rsel_m ? af_m : ae_m;
        @(negedge rd_clk); load_n = 0; rd_en_n = 0;
        @(negedge rd_clk); rd_en_n = 1; load_n = 1;
        rsel_m = !rsel_m; last_q = DW'(exp); loaded_m = 1;
        chk(dout === DW'(exp), tag, dout, exp);
    endtask

    task automatic settle();
        repeat (6) @(negedge wr_clk);
        repeat (6) @(negedge rd_clk);
    endtask

    task automatic check_flags(input string where);
        int n;
        n = model.size();
        chk(full_n === (n != DEPTH), {"R8 full_n ", where}, full_n, n != DEPTH);
        chk(empty_n === (n != 0), {"R8 R11 empty_n ", where}, empty_n, n != 0);
        chk(half_n === !(n > DEPTH / 2), {"R7 half_n ", where}, half_n, !(n > DEPTH / 2));
        chk(almost_empty_n === !(n <= ae_m), {"R5 almost_empty_n ", where},
            almost_empty_n, !(n <= ae_m));
        chk(almost_full_n === !((DEPTH - n) <= af_m), {"R6 almost_full_n ", where},
            almost_full_n, !((DEPTH - n) <= af_m));
    endtask

    task automatic do_reset();
        @(negedge wr_clk); rst_n = 0;
        repeat (4) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
        rst_n = 1;
        model.delete();
        ae_m = 127; af_m = 127; wsel_m = 0; rsel_m = 0; loaded_m = 0; last_q = '0;
        settle();
    endtask

    task automatic fill_to(input int target);
        while (model.size() < target) push(DW'($urandom));
    endtask

    initial begin
        #750000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        do_reset();
        // R1: reset state
        check_flags("after reset R1");
        chk(dout === '0, "R1 output register cleared", dout, 0);
        chk(dout_valid === 1'b0, "R9 valid low before any read", dout_valid, 0);

        // R10 defaults and R4 readback; load reads leave FIFO empty
        cfg_read("R10 R4 default empty offset");
        cfg_read("R10 R4 default full offset");
        chk(dout[17:12] === 6'd0, "R4 upper readback bits zero", dout[17:12], 0);
        settle();
        chk(empty_n === 1'b0, "R4 load read removes nothing", empty_n, 0);

        // Program offsets 5 and 9 and read them back
        cfg_write(5); cfg_write(9);
        cfg_read("R4 programmed empty offset");
        cfg_read("R4 programmed full offset");

        // R3: read at empty holds output
        pop("R3 read while empty holds");

        // Boundary walk through thresholds
        fill_to(5);    settle(); check_flags("count 5");
        fill_to(6);    settle(); check_flags("count 6");
        fill_to(512);  settle(); check_flags("count 512");
        fill_to(513);  settle(); check_flags("count 513");
        fill_to(1014); settle(); check_flags("count 1014");
        fill_to(1015); settle(); check_flags("count 1015");
        fill_to(1023); settle(); check_flags("count 1023");
        fill_to(1024); settle(); check_flags("count 1024");
        // R2: writes while full are dropped
        push(18'h3FFFF); push(18'h2AAAA); push(18'h15555);
        settle(); check_flags("R2 after writes at full");
        // R4: config write while full does not alter contents
        cfg_write(5);
        settle(); check_flags("R4 config write at full");
        cfg_write(9);

        // R9: output enable gating
        pop("R3 first word out");
        oe_n = 1; #1;
        chk(dout === '0, "R9 dout zero when disabled", dout, 0);
        chk(dout_valid === 1'b0, "R9 valid low when disabled", dout_valid, 0);
        oe_n = 0; #1;
        chk(dout === last_q, "R9 dout restored when enabled", dout, last_q);
        chk(dout_valid === 1'b1, "R9 valid high after read", dout_valid, 1);

        // Drain and read past empty
        while (model.size() > 0) pop("R3 drain order");
        pop("R3 read at empty holds last word");
        pop("R3 second read at empty holds");
        settle(); check_flags("drained");

        // Random bursts
        for (int ph = 0; ph < 40; ph++) begin
            int op, n;
            op = $urandom % 3;
            n = $urandom % 400;
            if (op == 0) begin
                for (int k = 0; k < n; k++) push(DW'($urandom));
            end else if (op == 1) begin
                for (int k = 0; k < n; k++) pop("R3 random read data");
            end else begin
                cfg_write($urandom % 1100);
                cfg_write($urandom % 1100);
                if (rsel_m) cfg_read("R10 realign read selector");
                cfg_read("R4 random empty offset");
                cfg_read("R4 random full offset");
            end
            settle(); check_flags("random phase");
        end

        // R10: selector and offsets return to defaults after reset
        if (!wsel_m) cfg_write(77);
        if (!rsel_m) cfg_read("R4 selector set to full side");
        fill_to(20);
        do_reset();
        check_flags("R1 second reset");
        chk(dout_valid === 1'b0, "R1 R9 valid cleared by reset", dout_valid, 0);
        cfg_read("R10 reset empty offset 127");
        cfg_read("R10 reset full offset 127");
        cfg_write(200);
        cfg_read("R10 first load write hits empty offset");
        cfg_read("R10 full offset untouched");
        chk(ae_m == 200 && af_m == 127, "R10 model selector", ae_m, 200);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule